// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block moves 36-bit words from one clock domain to another through a 64-word store. The write side and the read side run on unrelated clocks. Each side sees only the status flags that belong to it. The write side gets a full flag and an almost-full flag. The read side gets an empty flag and an almost-empty flag. Every flag is active low.

Each flag is computed from the local pointer and a copy of the remote pointer. The remote pointer crosses the clock boundary in Gray code through two flip-flops. As a result, a flag that reports more room or more data clears on the second local clock edge after the event on the far side. A flag that reports less room or less data updates on the local edge itself.

The almost-empty and almost-full flags use a threshold X. X is chosen by a 2-bit select input and is frozen when reset is released. The read data sits in an output register, and that register loads only on an accepted read.

Top module: `dc_flag_fifo`

## Requirements
- R1: While reset is low, the flags read full_n=0, empty_n=0, aempty_n=0 and afull_n=1, and rdata reads all zeros.
- R2: After reset is released, full_n stays low through the first rising wclk edge and goes high on the second one.
- R3: The threshold X is taken from ofs_sel as sampled during reset. The encodings are 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 12 and 2'b11 gives 16. X holds at that value after reset is released.
- R4: Words come out in the order they were accepted. Up to 64 words of 36 bits are held without loss.
- R5: A write attempted while full_n is low is ignored, and the stored contents stay unchanged.
- R6: A read attempted while empty_n is low is ignored: rdata keeps its value and no word is consumed.
- R7: rdata changes only on a rising rclk edge with ren high and empty_n high. With ren low, rdata holds its value.
- R8: A write into an empty FIFO leaves empty_n low after the first rising rclk edge following the write edge. empty_n goes high on the second such edge.
- R9: Once both domains have settled, empty_n is low exactly when the FIFO holds 0 words, and aempty_n is low exactly when it holds X or fewer words.
- R10: Once settled, afull_n is low exactly when the FIFO holds 64−X or more words.
- R11: full_n is low exactly when the FIFO holds 64 words. It falls on the write edge that stores the 64th word.
- R12: After a read from a full FIFO, full_n stays low through the first rising wclk edge after the read edge and goes high on the second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset; assertion may be asynchronous to both clocks |
| ofs_sel | input | 2 | Threshold select, sampled while reset is low |
| wclk | input | 1 | Write-side clock |
| wen | input | 1 | Write request |
| wdata | input | 36 | Write word |
| full_n | output | 1 | Low when no location is free (write domain) |
| afull_n | output | 1 | Low at 64−X or more words (write domain) |
| rclk | input | 1 | Read-side clock |
| ren | input | 1 | Read request |
| rdata | output | 36 | Registered read word |
| empty_n | output | 1 | Low when no word is readable (read domain) |
| aempty_n | output | 1 | Low at X or fewer words (read domain) |

## Verification
The first pattern fills the FIFO one word at a time and then drains it one word at a time, once for each of the four threshold codes. The flags are compared at every fill level, so a wrong code decode, an off-by-one boundary compare or a swapped flag shows up as a mismatch at a single level.

The second pattern tries writes at 64 words and reads at 0 words. These attempts must leave the data stream and rdata untouched, which separates correct gating from overwrite or underflow.

The third pattern counts edges individually after a write into an empty FIFO and after a read from a full one. This tells the two-flop latency apart from a one-flop or three-flop path.

The last pattern is a long stream with irregular enables on both sides. It exercises the pointer crossing where the two clocks slide past each other in phase.

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo #(
  parameter int DW       = 36,
  parameter int AW       = 6,
  parameter int OFS_STEP = 4
) (
  input  logic          rst_n,
  input  logic [1:0]    ofs_sel,
  input  logic          wclk,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          full_n,
  output logic          afull_n,
  input  logic          rclk,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] thr(input logic [1:0] code);
    return PW'((int'(code) + 1) * OFS_STEP);
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, xw, wcnt;
  logic [1:0]    wrdy;
  logic          wr_go;
  logic [PW-1:0] wbin_nx;

  assign wr_go   = wen & full_n;
  assign wbin_nx = wbin + PW'(wr_go);
  assign wcnt    = wbin - g2b(rg_s2);
  assign full_n  = wrdy[1] & (wcnt != DEPTH_P);
  assign afull_n = ~wrdy[1] | (wcnt < (DEPTH_P - xw));

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      wrdy  <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= b2g(wbin_nx);
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      wrdy  <= {wrdy[0], 1'b1};
    end

  always_ff @(posedge wclk)
    if (!rst_n) xw <= thr(ofs_sel);

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= wdata;

  // read domain
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2, xr, rcnt;
  logic          rrdy;
  logic          rd_go;
  logic [PW-1:0] rbin_nx;

  assign rd_go    = ren & empty_n;
  assign rbin_nx  = rbin + PW'(rd_go);
  assign rcnt     = g2b(wg_s2) - rbin;
  assign empty_n  = (rcnt != '0);
  assign aempty_n = rrdy & (rcnt > xr);

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      rrdy  <= 1'b0;
      rdata <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= b2g(rbin_nx);
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      rrdy  <= 1'b1;
      if (rd_go) rdata <= mem[rbin[AW-1:0]];
    end

  always_ff @(posedge rclk)
    if (!rst_n) xr <= thr(ofs_sel);

  // checks
  p_wlevel_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    wcnt <= DEPTH_P);
  p_rlevel_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    rcnt <= DEPTH_P);
  p_no_overflow_r5: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen && !full_n) |=> (wbin == $past(wbin)));
  p_no_underflow_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren && !empty_n) |=> $stable(rdata));
  p_hold_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    !ren |=> $stable(rdata));
  p_nest_r_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    aempty_n |-> empty_n);
  p_nest_w_r10: assert property (@(posedge wclk) disable iff (!rst_n)
    (wrdy[1] && !full_n) |-> !afull_n);
endmodule

// File: tb/sim_dc_flag_fifo.sv
`timescale 1ns/10ps
module sim_dc_flag_fifo;
  logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, wen = 1'b0, ren = 1'b0;
  logic [1:0]  ofs_sel = 2'b00;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        full_n, afull_n, empty_n, aempty_n;

  dc_flag_fifo u0 (
    .rst_n(rst_n), .ofs_sel(ofs_sel),
    .wclk(wclk), .wen(wen), .wdata(wdata), .full_n(full_n), .afull_n(afull_n),
    .rclk(rclk), .ren(ren), .rdata(rdata), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  always #2.5 wclk = ~wclk;
  initial begin
    #0.25;
    forever #3.5 rclk = ~rclk;
  end

  int total = 0, bad = 0, cur_x = 4;
  logic [35:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge wclk)
    if (rst_n && wen && full_n) exp_q.push_back(wdata);

  initial begin
    logic acc;
    logic [35:0] e;
    forever begin
      @(negedge rclk);
      acc = rst_n && ren && empty_n;
      @(posedge rclk);
      #0.5;
      if (acc) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 read with nothing expected", rdata, '0);
        else begin
          e = exp_q.pop_front();
          chk(rdata === e, "R4 data order", rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [35:0] d);
    @(posedge wclk); #1; wen = 1'b1; wdata = d;
    @(posedge wclk); #1; wen = 1'b0;
  endtask

  task automatic rd();
    @(posedge rclk); #1; ren = 1'b1;
    @(posedge rclk); #1; ren = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    #0.5;
  endtask

  task automatic check_flags(input int n);
    chk(empty_n === (n != 0), "R9 empty_n level", 36'(empty_n), 36'(n != 0));
    chk(aempty_n === (n > cur_x), "R9 aempty_n level with R3 threshold", 36'(aempty_n), 36'(n > cur_x));
    chk(afull_n === (n < 64 - cur_x), "R10 afull_n level with R3 threshold", 36'(afull_n), 36'(n < 64 - cur_x));
    chk(full_n === (n != 64), "R11 full_n level", 36'(full_n), 36'(n != 64));
  endtask

  task automatic do_reset(input logic [1:0] code);
    rst_n = 1'b0; ofs_sel = code; wen = 1'b0; ren = 1'b0;
    repeat (8) @(posedge wclk);
    #0.5;
    chk(full_n === 1'b0, "R1 full_n in reset", 36'(full_n), 36'd0);
    chk(empty_n === 1'b0, "R1 empty_n in reset", 36'(empty_n), 36'd0);
    chk(aempty_n === 1'b0, "R1 aempty_n in reset", 36'(aempty_n), 36'd0);
    chk(afull_n === 1'b1, "R1 afull_n in reset", 36'(afull_n), 36'd1);
    chk(rdata === '0, "R1 rdata in reset", rdata, '0);
    exp_q.delete();
    cur_x = 4 * (int'(code) + 1);
    @(negedge wclk); rst_n = 1'b1;
    @(posedge wclk); #0.5;
    chk(full_n === 1'b0, "R2 full_n after first edge", 36'(full_n), 36'd0);
    @(posedge wclk); #0.5;
    chk(full_n === 1'b1, "R2 full_n after second edge", 36'(full_n), 36'd1);
  endtask

  initial begin
    #900000;
    chk(1'b0, "watchdog expired", '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [35:0] last;
    bit wdone;
    for (int c = 0; c < 4; c++) begin
      do_reset(2'(c));
      settle();
      check_flags(0);
      for (int n = 1; n <= 64; n++) begin
        wr(36'(n * 32'h9E3779B1) ^ {c[3:0], 32'h0} ^ 36'(n << 20));
        settle();
        check_flags(n);
      end
      // R5: write at 64 words must be dropped
      wr(36'hBAD_BAD_BA);
      settle();
      check_flags(64);
      // R12: two-edge release of full_n after a read
      @(posedge rclk); #1; ren = 1'b1;
      @(posedge rclk);
      fork begin #1; ren = 1'b0; end join_none
      @(posedge wclk); #0.5;
      chk(full_n === 1'b0, "R12 full_n after first wclk edge", 36'(full_n), 36'd0);
      @(posedge wclk); #0.5;
      chk(full_n === 1'b1, "R12 full_n after second wclk edge", 36'(full_n), 36'd1);
      settle();
      check_flags(63);
      for (int n = 63; n >= 1; n--) begin
        rd();
        settle();
        check_flags(n - 1);
      end
      last = rdata;
      settle();
      chk(rdata === last, "R7 rdata holds while idle", rdata, last);
      // R6: read on empty
      rd();
      settle();
      chk(rdata === last, "R6 rdata after read on empty", rdata, last);
      chk(empty_n === 1'b0, "R6 still empty after read on empty", 36'(empty_n), 36'd0);
      // R8: two-edge release of empty_n after a write
      @(posedge wclk); #1; wen = 1'b1; wdata = 36'h5A5A_0000_0 | 36'(c);
      @(posedge wclk);
      fork begin #1; wen = 1'b0; end join_none
      @(posedge rclk); #0.5;
      chk(empty_n === 1'b0, "R8 empty_n after first rclk edge", 36'(empty_n), 36'd0);
      @(posedge rclk); #0.5;
      chk(empty_n === 1'b1, "R8 empty_n after second rclk edge", 36'(empty_n), 36'd1);
      rd();
      settle();
      check_flags(0);
    end

    // R4: streaming with irregular enables on both sides
    wdone = 1'b0;
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          repeat ($urandom % 3) @(posedge wclk);
          wr({4'hC, 32'(i * 32'h01000193)});
        end
        wdone = 1'b1;
      end
      begin
        while (!wdone || exp_q.size() != 0) begin
          @(posedge rclk); #1;
          ren = (($urandom % 3) != 0);
        end
        ren = 1'b0;
      end
    join
    settle();
    chk(exp_q.size() == 0, "R4 all streamed words delivered", 36'(exp_q.size()), '0);
    chk(empty_n === 1'b0, "R9 empty after stream", 36'(empty_n), 36'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule